// File: doc/BRIEF.md
# Stream Throughput Profiling Counter

This unit watches one valid/ready stream without touching it and measures how fast data moves across it. A small pool of saturating counters serves it. A command port lets the caller claim counters, read them and give them back. Each command gets a registered response one cycle later.

There are two measurement modes:

- **Beat mode** takes one counter. It counts accepted transfers from the cycle after the start command, for as long as the handle is held. It keeps counting whether or not the traffic ever stops.
- **Byte-budget mode** takes an aligned pair of counters. One counts elapsed cycles and the other counts bytes moved. The clock does not start at the command: it starts on the first accepted transfer. Both counters freeze in the cycle where the byte total reaches the programmed budget. From then on the elapsed-cycle figure is the time taken to move that budget.

The pool is small, two counters by default. A start that cannot be served returns a reserved invalid handle and no counter is claimed.

Top module: `strm_prof_unit`

## Requirements
- R1: After reset no counter is claimed. A read of any handle answers with rsp_ok_o low and rsp_value_o zero.
- R2: A start with cmd_cyc_mode_i low claims the lowest free counter and returns its index as the handle. A start with cmd_cyc_mode_i high needs an even/odd counter pair that is wholly free, and returns the even index. Counter numbers that are not a handle (the odd half of a pair) read back rsp_ok_o low.
- R3: When a start cannot be served, the response carries rsp_ok_o low and the all-ones handle code (2'b11 at the default pool size), and no counter changes owner.
- R4: In beat mode the count rises by one for each cycle in which s_valid_i and s_ready_i are both high. The first such cycle that can count is the cycle after the start command. Valid without ready, and ready without valid, add nothing.
- R5: In byte-budget mode, cycles before the first accepted transfer are not counted, however long the gap.
- R6: The byte-budget result spans from the cycle of the first accepted transfer to the cycle where the byte total (BEAT_BYTES per transfer) first reaches or exceeds the budget, both cycles included. Stall cycles in between are included.
- R7: In byte-budget mode, a read before the budget is reached returns the running cycle count with rsp_done_o low. Once the budget is reached the value is frozen and reads return it with rsp_done_o high, even if traffic continues.
- R8: In beat mode a read returns the beats counted so far with rsp_done_o low and does not stop or reset the count.
- R9: Counters saturate at all ones instead of wrapping.
- R10: A free command on a valid handle returns its counter (or pair) to the pool with rsp_ok_o high. Later reads of that handle return rsp_ok_o low, and a new start on it counts from zero.
- R11: Every command with cmd_valid_i high gives exactly one cycle of rsp_valid_o in the following cycle. cmd_op_i encodes start as 0, read as 1 and free as 2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| s_valid_i | input | 1 | Valid of the observed stream |
| s_ready_i | input | 1 | Ready of the observed stream |
| cmd_valid_i | input | 1 | Command strobe |
| cmd_op_i | input | 2 | 0 start, 1 read, 2 free |
| cmd_cyc_mode_i | input | 1 | Start mode: 0 beat count, 1 byte budget |
| cmd_handle_i | input | HW | Handle for read and free |
| cmd_bytes_i | input | CNT_W | Byte budget for a byte-budget start |
| rsp_valid_o | output | 1 | Response strobe |
| rsp_ok_o | output | 1 | Command succeeded |
| rsp_handle_o | output | HW | Granted handle, or the all-ones code |
| rsp_value_o | output | CNT_W | Counter value on a read |
| rsp_done_o | output | 1 | Byte budget reached |

## Verification
The bench builds the unit with CNT_W set to 8, BEAT_BYTES at 4 and a pool of two counters. The 8-bit counters let a few hundred continuous beats drive a count to saturation within a short run. The two-counter pool means that one byte-budget start, or two beat starts, exhaust it. Refusal, pair alignment and reuse after free are therefore all reached with only a handful of commands.

// File: rtl/strm_prof_pkg.sv
package strm_prof_pkg;

  typedef enum logic [1:0] {
    OP_START = 2'd0,
    OP_READ  = 2'd1,
    OP_FREE  = 2'd2,
    OP_NONE  = 2'd3
  } prof_op_e;

  typedef enum logic [1:0] {
    ROLE_EVT = 2'd0,
    ROLE_CYC = 2'd1,
    ROLE_BYT = 2'd2
  } slot_role_e;

endpackage

// File: rtl/strm_prof_mon.sv
module strm_prof_mon #(
  parameter int CNT_W      = 32,
  parameter int BEAT_BYTES = 4
) (
  input  logic             valid_i,
  input  logic             ready_i,
  output logic             beat_o,
  output logic [CNT_W-1:0] bytes_o
);

  assign beat_o  = valid_i & ready_i;
  assign bytes_o = beat_o ? CNT_W'(BEAT_BYTES) : '0;

endmodule

// File: rtl/strm_prof_alloc.sv
module strm_prof_alloc #(
  parameter int N_CNT = 2,
  localparam int IW   = $clog2(N_CNT)
) (
  input  logic [N_CNT-1:0] busy_i,
  input  logic             pair_i,
  output logic             ok_o,
  output logic [IW-1:0]    idx_o
);

  // lowest free slot, or lowest free aligned pair
  always_comb begin
    ok_o  = 1'b0;
    idx_o = '0;
    if (pair_i) begin
      for (int k = N_CNT/2 - 1; k >= 0; k--) begin
        if (!busy_i[2*k] && !busy_i[2*k+1]) begin
          ok_o  = 1'b1;
          idx_o = IW'(2*k);
        end
      end
    end else begin
      for (int k = N_CNT - 1; k >= 0; k--) begin
        if (!busy_i[k]) begin
          ok_o  = 1'b1;
          idx_o = IW'(k);
        end
      end
    end
  end

endmodule

// File: rtl/strm_prof_slot.sv
module strm_prof_slot #(
  parameter int CNT_W = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic             en_i,
  input  logic [CNT_W-1:0] inc_i,
  output logic [CNT_W-1:0] cnt_o
);

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W:0]   sum;

  assign sum   = {1'b0, cnt_q} + {1'b0, inc_i};
  assign cnt_o = cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      cnt_q <= '0;
    else if (clr_i)   cnt_q <= '0;
    else if (en_i)    cnt_q <= sum[CNT_W] ? '1 : sum[CNT_W-1:0];
  end

  p_sat_hold_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnt_q == '1 && !clr_i) |=> (cnt_q == '1));

  p_no_wrap_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !clr_i |=> (cnt_q >= $past(cnt_q)));

endmodule

// File: rtl/strm_prof_unit.sv
module strm_prof_unit
  import strm_prof_pkg::*;
#(
  parameter int  N_CNT      = 2,
  parameter int  CNT_W      = 32,
  parameter int  BEAT_BYTES = 4,
  localparam int IW         = $clog2(N_CNT),
  localparam int HW         = IW + 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             s_valid_i,
  input  logic             s_ready_i,
  input  logic             cmd_valid_i,
  input  logic [1:0]       cmd_op_i,
  input  logic             cmd_cyc_mode_i,
  input  logic [HW-1:0]    cmd_handle_i,
  input  logic [CNT_W-1:0] cmd_bytes_i,
  output logic             rsp_valid_o,
  output logic             rsp_ok_o,
  output logic [HW-1:0]    rsp_handle_o,
  output logic [CNT_W-1:0] rsp_value_o,
  output logic             rsp_done_o
);

  logic             beat;
  logic [CNT_W-1:0] beat_bytes;

  logic [N_CNT-1:0] busy_q, armed_q, done_q;
  slot_role_e       role_q   [N_CNT];
  logic [CNT_W-1:0] target_q [N_CNT];
  logic [CNT_W-1:0] cnt      [N_CNT];
  logic [N_CNT-1:0] run, reach, en, clr;

  logic             alloc_ok;
  logic [IW-1:0]    alloc_idx;
  prof_op_e         op;
  logic [IW-1:0]    hidx;
  logic             hvalid, start_go, free_go, free_pair;

  strm_prof_mon #(.CNT_W(CNT_W), .BEAT_BYTES(BEAT_BYTES)) u_mon (
    .valid_i (s_valid_i),
    .ready_i (s_ready_i),
    .beat_o  (beat),
    .bytes_o (beat_bytes)
  );

  strm_prof_alloc #(.N_CNT(N_CNT)) u_alloc (
    .busy_i (busy_q),
    .pair_i (cmd_cyc_mode_i),
    .ok_o   (alloc_ok),
    .idx_o  (alloc_idx)
  );

  assign op        = prof_op_e'(cmd_op_i);
  assign hidx      = cmd_handle_i[IW-1:0];
  assign hvalid    = (cmd_handle_i < HW'(N_CNT)) && busy_q[hidx] && (role_q[hidx] != ROLE_BYT);
  assign start_go  = cmd_valid_i && (op == OP_START) && alloc_ok;
  assign free_go   = cmd_valid_i && (op == OP_FREE) && hvalid;
  assign free_pair = role_q[hidx] == ROLE_CYC;

  for (genvar i = 0; i < N_CNT; i++) begin : g_slot
    localparam int P = i ^ 1;

    // cycle clock runs from first beat until budget met
    assign run[i]   = busy_q[i] && (role_q[i] == ROLE_CYC) && !done_q[i] && (armed_q[i] || beat);
    assign reach[i] = ({1'b0, cnt[P]} + {1'b0, beat_bytes}) >= {1'b0, target_q[i]};
    assign en[i]    = ((role_q[i] == ROLE_EVT) && busy_q[i] && beat)
                    || ((role_q[i] == ROLE_CYC) && run[i])
                    || ((role_q[i] == ROLE_BYT) && busy_q[i] && run[P] && beat);
    assign clr[i]   = (start_go && ((IW'(i) == alloc_idx) ||
                                    (cmd_cyc_mode_i && (IW'(i) == (alloc_idx | IW'(1))))))
                    || (free_go && ((IW'(i) == hidx) ||
                                    (free_pair && (IW'(i) == (hidx ^ IW'(1))))));

    strm_prof_slot #(.CNT_W(CNT_W)) u_slot (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .clr_i  (clr[i]),
      .en_i   (en[i]),
      .inc_i  ((role_q[i] == ROLE_BYT) ? CNT_W'(BEAT_BYTES) : CNT_W'(1)),
      .cnt_o  (cnt[i])
    );

    p_frozen_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (busy_q[i] && role_q[i] == ROLE_CYC && done_q[i] && !clr[i]) |=> $stable(cnt[i]));

    p_idle_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (busy_q[i] && role_q[i] == ROLE_CYC && !armed_q[i] && !beat && !clr[i]) |=> (cnt[i] == '0));

    p_evt_hold_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (busy_q[i] && role_q[i] == ROLE_EVT && !beat && !clr[i]) |=> $stable(cnt[i]));
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q       <= '0;
      armed_q      <= '0;
      done_q       <= '0;
      for (int i = 0; i < N_CNT; i++) begin
        role_q[i]   <= ROLE_EVT;
        target_q[i] <= '0;
      end
      rsp_valid_o  <= 1'b0;
      rsp_ok_o     <= 1'b0;
      rsp_handle_o <= '0;
      rsp_value_o  <= '0;
      rsp_done_o   <= 1'b0;
    end else begin
      for (int i = 0; i < N_CNT; i++) begin
        if (run[i])             armed_q[i] <= 1'b1;
        if (run[i] && reach[i]) done_q[i]  <= 1'b1;
      end
      rsp_valid_o  <= cmd_valid_i;
      rsp_ok_o     <= 1'b0;
      rsp_handle_o <= cmd_handle_i;
      rsp_value_o  <= '0;
      rsp_done_o   <= 1'b0;
      if (cmd_valid_i) begin
        unique case (op)
          OP_START: begin
            if (alloc_ok) begin
              rsp_ok_o            <= 1'b1;
              rsp_handle_o        <= {1'b0, alloc_idx};
              busy_q[alloc_idx]   <= 1'b1;
              armed_q[alloc_idx]  <= 1'b0;
              done_q[alloc_idx]   <= 1'b0;
              target_q[alloc_idx] <= cmd_bytes_i;
              role_q[alloc_idx]   <= cmd_cyc_mode_i ? ROLE_CYC : ROLE_EVT;
              if (cmd_cyc_mode_i) begin
                busy_q[alloc_idx | IW'(1)] <= 1'b1;
                role_q[alloc_idx | IW'(1)] <= ROLE_BYT;
              end
            end else begin
              rsp_handle_o <= '1;
            end
          end
          OP_READ: begin
            if (hvalid) begin
              rsp_ok_o    <= 1'b1;
              rsp_value_o <= cnt[hidx];
              rsp_done_o  <= done_q[hidx] && (role_q[hidx] == ROLE_CYC);
            end
          end
          OP_FREE: begin
            if (hvalid) begin
              rsp_ok_o     <= 1'b1;
              busy_q[hidx] <= 1'b0;
              if (free_pair) busy_q[hidx ^ IW'(1)] <= 1'b0;
            end
          end
          default: ;
        endcase
      end
    end
  end

  p_rsp_pulse_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_valid_i |=> rsp_valid_o);

  p_rsp_quiet_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cmd_valid_i |=> !rsp_valid_o);

  p_refuse_code_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_valid_i && cmd_op_i == 2'd0 && !alloc_ok) |=> (rsp_handle_o == '1 && !rsp_ok_o));

  p_refuse_keep_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_valid_i && cmd_op_i == 2'd0 && !alloc_ok) |=> $stable(busy_q));

endmodule

// File: tb/strm_prof_unit_test.sv
module strm_prof_unit_test;

  localparam int CLK_PERIOD = 10;
  localparam int N_CNT      = 2;
  localparam int CNT_W      = 8;
  localparam int BEAT_BYTES = 4;
  localparam int HW         = 2;
  localparam int N_VEC      = 9;

  // {cyc_mode, budget[7:0], valid[15:0], ready[15:0], exp_value[7:0], exp_done}
  localparam logic [49:0] TBL [N_VEC] = '{
    {1'b0, 8'd0,  16'hFFFF, 16'hFFFF, 8'd16, 1'b0},
    {1'b0, 8'd0,  16'h00FF, 16'h0F0F, 8'd4,  1'b0},
    {1'b0, 8'd0,  16'hAAAA, 16'hFFFF, 8'd8,  1'b0},
    {1'b0, 8'd0,  16'hFFFF, 16'h0000, 8'd0,  1'b0},
    {1'b1, 8'd16, 16'hFFF0, 16'hFFF0, 8'd4,  1'b1},
    {1'b1, 8'd12, 16'hFF2A, 16'hFFFF, 8'd5,  1'b1},
    {1'b1, 8'd13, 16'h000F, 16'h000F, 8'd4,  1'b1},
    {1'b1, 8'd64, 16'h00FF, 16'hFFFF, 8'd16, 1'b0},
    {1'b1, 8'd16, 16'hFFFF, 16'h0F50, 8'd6,  1'b1}
  };

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             s_valid = 1'b0, s_ready = 1'b0;
  logic             cmd_valid = 1'b0;
  logic [1:0]       cmd_op = 2'd0;
  logic             cmd_cyc = 1'b0;
  logic [HW-1:0]    cmd_handle = '0;
  logic [CNT_W-1:0] cmd_bytes = '0;
  logic             rsp_valid, rsp_ok, rsp_done;
  logic [HW-1:0]    rsp_handle;
  logic [CNT_W-1:0] rsp_value;

  int n_chk = 0;
  int n_bad = 0;
  bit finished = 0;

  logic             r_valid, r_ok, r_done;
  logic [HW-1:0]    r_handle;
  logic [CNT_W-1:0] r_value;

  always #(CLK_PERIOD/2) clk = ~clk;

  strm_prof_unit #(.N_CNT(N_CNT), .CNT_W(CNT_W), .BEAT_BYTES(BEAT_BYTES)) uut (
    .clk_i          (clk),
    .rst_ni         (rst_n),
    .s_valid_i      (s_valid),
    .s_ready_i      (s_ready),
    .cmd_valid_i    (cmd_valid),
    .cmd_op_i       (cmd_op),
    .cmd_cyc_mode_i (cmd_cyc),
    .cmd_handle_i   (cmd_handle),
    .cmd_bytes_i    (cmd_bytes),
    .rsp_valid_o    (rsp_valid),
    .rsp_ok_o       (rsp_ok),
    .rsp_handle_o   (rsp_handle),
    .rsp_value_o    (rsp_value),
    .rsp_done_o     (rsp_done)
  );

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // called at a negedge; returns at the negedge after the response edge
  task automatic issue(input logic [1:0] op, input logic cyc, input logic [HW-1:0] h,
                       input logic [CNT_W-1:0] bytes);
    cmd_valid  = 1'b1;
    cmd_op     = op;
    cmd_cyc    = cyc;
    cmd_handle = h;
    cmd_bytes  = bytes;
    @(negedge clk);
    cmd_valid = 1'b0;
    r_valid  = rsp_valid;
    r_ok     = rsp_ok;
    r_handle = rsp_handle;
    r_value  = rsp_value;
    r_done   = rsp_done;
  endtask

  task automatic drive(input logic v, input logic r, input int n);
    s_valid = v;
    s_ready = r;
    repeat (n) @(negedge clk);
    s_valid = 1'b0;
    s_ready = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1: nothing claimed after reset
    check("R1 rsp_valid idle", int'(rsp_valid), 0);
    issue(2'd1, 1'b0, 2'd0, '0);
    check("R1 read h0 ok", int'(r_ok), 0);
    check("R1 read h0 value", int'(r_value), 0);
    issue(2'd1, 1'b0, 2'd1, '0);
    check("R1 read h1 ok", int'(r_ok), 0);
    // R11: one response cycle per command
    check("R11 rsp_valid pulse", int'(r_valid), 1);
    @(negedge clk);
    check("R11 rsp_valid drops", int'(rsp_valid), 0);

    // table walk
    for (int e = 0; e < N_VEC; e++) begin
      logic        cyc;
      logic [7:0]  bud, ev;
      logic [15:0] vp, rp;
      logic        ed;
      {cyc, bud, vp, rp, ev, ed} = TBL[e];
      issue(2'd0, cyc, '0, bud);
      check("R2 start ok", int'(r_ok), 1);
      check("R2 start handle", int'(r_handle), 0);
      for (int k = 0; k < 16; k++) begin
        s_valid = vp[k];
        s_ready = rp[k];
        @(negedge clk);
      end
      s_valid = 1'b0;
      s_ready = 1'b0;
      issue(2'd1, 1'b0, 2'd0, '0);
      if (cyc) begin
        check("R6 budget cycles", int'(r_value), int'(ev));
        check("R7 done flag", int'(r_done), int'(ed));
      end else begin
        check("R4 beat count", int'(r_value), int'(ev));
        check("R8 done low", int'(r_done), 0);
      end
      issue(2'd2, 1'b0, 2'd0, '0);
      check("R10 free ok", int'(r_ok), 1);
    end

    // R5: long idle before first beat not counted
    issue(2'd0, 1'b1, '0, 8'd8);
    repeat (40) @(negedge clk);
    drive(1'b1, 1'b1, 2);
    repeat (5) @(negedge clk);
    issue(2'd1, 1'b0, 2'd0, '0);
    check("R5 idle excluded", int'(r_value), 2);
    check("R7 frozen done", int'(r_done), 1);
    // R2: odd half of pair is not a handle
    issue(2'd1, 1'b0, 2'd1, '0);
    check("R2 odd half read", int'(r_ok), 0);
    // R3: pool exhausted by one pair
    issue(2'd0, 1'b0, '0, '0);
    check("R3 refuse ok", int'(r_ok), 0);
    check("R3 refuse code", int'(r_handle), 3);
    issue(2'd2, 1'b0, 2'd0, '0);
    // R10: freed handle invalid
    issue(2'd1, 1'b0, 2'd0, '0);
    check("R10 read after free", int'(r_ok), 0);

    // R2/R3 with beat-mode allocation
    issue(2'd0, 1'b0, '0, '0);
    check("R2 first beat handle", int'(r_handle), 0);
    issue(2'd0, 1'b0, '0, '0);
    check("R2 second beat handle", int'(r_handle), 1);
    issue(2'd0, 1'b0, '0, '0);
    check("R3 third refused", int'(r_handle), 3);
    issue(2'd2, 1'b0, 2'd0, '0);
    issue(2'd0, 1'b1, '0, 8'd4);
    check("R2 pair needs both free", int'(r_ok), 0);
    // R8: read does not disturb counting on handle 1
    drive(1'b1, 1'b1, 5);
    issue(2'd1, 1'b0, 2'd1, '0);
    check("R8 first read", int'(r_value), 5);
    drive(1'b1, 1'b1, 3);
    issue(2'd1, 1'b0, 2'd1, '0);
    check("R8 second read", int'(r_value), 8);
    check("R8 done stays low", int'(r_done), 0);
    // R4: same-cycle beat with start is not counted
    s_valid = 1'b1;
    s_ready = 1'b1;
    issue(2'd0, 1'b0, '0, '0);
    s_valid = 1'b0;
    s_ready = 1'b0;
    issue(2'd1, 1'b0, 2'd0, '0);
    check("R4 start-cycle beat", int'(r_value), 0);
    // R9: saturation
    drive(1'b1, 1'b1, 300);
    issue(2'd1, 1'b0, 2'd0, '0);
    check("R9 saturate", int'(r_value), 255);
    issue(2'd2, 1'b0, 2'd0, '0);
    issue(2'd2, 1'b0, 2'd1, '0);
    check("R10 free h1", int'(r_ok), 1);
    // R10: reuse starts from zero
    issue(2'd0, 1'b1, '0, 8'd100);
    check("R10 reuse handle", int'(r_handle), 0);
    issue(2'd1, 1'b0, 2'd0, '0);
    check("R10 reuse zero", int'(r_value), 0);
    issue(2'd2, 1'b0, 2'd3, '0);
    check("R10 bad handle free", int'(r_ok), 0);

    finished = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule